// File: doc/BRIEF.md
# Receiver Idle Time-out Counter

This block watches a serial receive path for silence once traffic has begun. The receiver supplies three things: a strobe once per bit period, a pulse when a character starts arriving, and a pulse when a character has been fully received. Software supplies an 8-bit time-out value and a restart command. The block does nothing until a first character begins after reset or after a restart. It then counts down one step per bit period and reloads the count every time a character completes.

One programmed unit is worth four bit periods, so the line must stay quiet for value × 4 bit periods before the block raises its time-out flag. The flag is sticky. Once it is set, the count stops. Only a restart clears the flag, and only a new first character arms the count again. A value of zero turns detection off.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset, `timeout_o` is 0 and the counter is dormant.
- R2: While dormant, bit ticks do nothing. The counter arms only on a `char_start_i` pulse.
- R3: A `limit_i` of 0 disables detection. A start pulse does not arm the counter. A reload with `limit_i` = 0 returns the block to dormant. `timeout_o` never sets.
- R4: After arming with value V (1..255), `timeout_o` goes to 1 at the clock edge that samples the 4·V-th bit tick counted from arming. It stays 0 before that edge.
- R5: A `char_done_i` pulse while armed reloads the full count of `limit_i`·4 ticks. If a tick arrives in the same cycle, the reload wins and that tick is not counted.
- R6: A change of `limit_i` while armed has no effect on the running count. The new value is used at the next reload or arming.
- R7: `timeout_o` is sticky. After expiry the counter stays stopped, and ticks, start pulses and done pulses change nothing until a restart.
- R8: `restart_i` clears `timeout_o` and returns the block to dormant on the next edge. It has priority over every other input in the same cycle.
- R9: A `char_start_i` pulse while armed does not reload the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| limit_i | input | 8 | Time-out value, in units of four bit periods |
| bit_tick_i | input | 1 | One-cycle strobe per bit period |
| char_done_i | input | 1 | One-cycle pulse when a character has been received |
| char_start_i | input | 1 | One-cycle pulse when a character begins |
| restart_i | input | 1 | Clears the flag and waits for a new first character |
| timeout_o | output | 1 | Sticky time-out flag |

## Verification
The hardest situations to reach are the coincidences: a reload arriving in the same cycle as a tick, and a restart arriving alongside a completed character. A directed task drives these inputs together in a single cycle. It then counts ticks from that point to show which input took effect. The longest window uses value 255, which takes 1020 ticks. The bench checks the flag one tick before the expected edge and again at it, so an off-by-one scale or compare shows up.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  typedef enum logic [1:0] {
    ST_WAIT    = 2'd0,
    ST_RUN     = 2'd1,
    ST_EXPIRED = 2'd2
  } rxto_state_e;
endpackage

// File: rtl/rxto_counter.sv
module rxto_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (load_i)                    cnt_q <= load_val_i;
    else if (step_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  // final step of the window
  assign last_o = step_i && (cnt_q == CNT_W'(1));

  assert_dec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !clr_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/rxto_ctrl.sv
module rxto_ctrl
  import rxto_pkg::*;
#(
  parameter int LIMIT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               bit_tick_i,
  input  logic               char_done_i,
  input  logic               char_start_i,
  input  logic               restart_i,
  input  logic               last_i,
  output logic               clr_o,
  output logic               load_o,
  output logic               step_o,
  output logic               flag_o
);
  rxto_state_e state_q, state_d;
  logic        flag_q;
  logic        limit_nz, armed, expire;

  assign limit_nz = (limit_i != '0);
  assign armed    = (state_q == ST_RUN);

  assign step_o = armed && bit_tick_i && !char_done_i && !restart_i;
  assign load_o = !restart_i && limit_nz &&
                  (((state_q == ST_WAIT) && char_start_i) || (armed && char_done_i));
  assign clr_o  = restart_i || (armed && char_done_i && !limit_nz);
  assign expire = armed && last_i && !restart_i;

  always_comb begin
    state_d = state_q;
    if (restart_i) state_d = ST_WAIT;
    else begin
      unique case (state_q)
        ST_WAIT:    if (load_o) state_d = ST_RUN;
        ST_RUN: begin
          if (char_done_i && !limit_nz) state_d = ST_WAIT;
          else if (expire)              state_d = ST_EXPIRED;
        end
        ST_EXPIRED: state_d = ST_EXPIRED;
        default:    state_d = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (restart_i)   flag_q <= 1'b0;
      else if (expire) flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  assert_zero_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WAIT) && limit_i == '0 && !restart_i) |=> (state_q == ST_WAIT));

  assert_rise_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(armed && bit_tick_i));

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !restart_i) |=> flag_q);

  assert_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!flag_q && state_q == ST_WAIT));

  assert_dormant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WAIT) && !char_start_i) |=> (state_q == ST_WAIT));
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout #(
  parameter int LIMIT_W    = 8,
  parameter int SCALE_LOG2 = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               bit_tick_i,
  input  logic               char_done_i,
  input  logic               char_start_i,
  input  logic               restart_i,
  output logic               timeout_o
);
  localparam int CNT_W = LIMIT_W + SCALE_LOG2;

  logic [CNT_W-1:0] load_val;
  logic clr, load, step, last;

  generate
    if (SCALE_LOG2 == 0) begin : g_noscale
      assign load_val = limit_i;
    end else begin : g_scale
      assign load_val = {limit_i, {SCALE_LOG2{1'b0}}};
    end
  endgenerate

  rxto_ctrl #(.LIMIT_W(LIMIT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .limit_i      (limit_i),
    .bit_tick_i   (bit_tick_i),
    .char_done_i  (char_done_i),
    .char_start_i (char_start_i),
    .restart_i    (restart_i),
    .last_i       (last),
    .clr_o        (clr),
    .load_o       (load),
    .step_o       (step),
    .flag_o       (timeout_o)
  );

  rxto_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .load_i     (load),
    .load_val_i (load_val),
    .step_i     (step),
    .last_o     (last)
  );
endmodule

// File: tb/sim_rx_idle_timeout.sv
`timescale 1ns/1ps
module sim_rx_idle_timeout;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] limit = 8'd0;
  logic       tick = 1'b0, done = 1'b0, start = 1'b0, restart = 1'b0;
  logic       tmo;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rx_idle_timeout u0 (
    .clk_i(clk), .rst_ni(rst_n), .limit_i(limit), .bit_tick_i(tick),
    .char_done_i(done), .char_start_i(start), .restart_i(restart), .timeout_o(tmo)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  task automatic chk(input logic exp, input string req);
    checks++;
    if (tmo !== exp) begin
      errors++;
      $display("FAIL %s: timeout_o actual=%b expected=%b", req, tmo, exp);
    end
  endtask

  // one cycle with the given pulses, ends at a negedge
  task automatic cyc(input logic s, input logic d, input logic t, input logic r);
    @(negedge clk);
    start = s; done = d; tick = t; restart = r;
    @(negedge clk);
    start = 0; done = 0; tick = 0; restart = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 0);
  endtask

  task automatic t_reset();
    chk(1'b0, "R1");
  endtask

  task automatic t_dormant();
    limit = 8'd2;
    ticks(20);
    chk(1'b0, "R2");
  endtask

  task automatic t_basic();
    cyc(1, 0, 0, 0);
    ticks(7);
    chk(1'b0, "R4");
    ticks(1);
    chk(1'b1, "R4");
    ticks(10);
    cyc(1, 0, 0, 0);
    cyc(0, 1, 0, 0);
    chk(1'b1, "R7");
  endtask

  task automatic t_restart();
    cyc(0, 0, 0, 1);
    chk(1'b0, "R8");
    ticks(20);
    chk(1'b0, "R7");
  endtask

  task automatic t_zero();
    cyc(0, 0, 0, 1);
    limit = 8'd0;
    cyc(1, 0, 0, 0);
    ticks(50);
    chk(1'b0, "R3");
    limit = 8'd1;
    cyc(1, 0, 0, 0);
    limit = 8'd0;
    cyc(0, 1, 0, 0);
    ticks(20);
    chk(1'b0, "R3");
  endtask

  task automatic t_reload();
    cyc(0, 0, 0, 1);
    limit = 8'd1;
    cyc(1, 0, 0, 0);
    ticks(3);
    cyc(0, 1, 0, 0);
    ticks(3);
    chk(1'b0, "R5");
    ticks(1);
    chk(1'b1, "R5");
    cyc(0, 0, 0, 1);
    cyc(1, 0, 0, 0);
    ticks(3);
    cyc(0, 1, 1, 0);
    ticks(3);
    chk(1'b0, "R5");
    ticks(1);
    chk(1'b1, "R5");
  endtask

  task automatic t_newlimit();
    cyc(0, 0, 0, 1);
    limit = 8'd1;
    cyc(1, 0, 0, 0);
    limit = 8'd3;
    ticks(4);
    chk(1'b1, "R6");
    cyc(0, 0, 0, 1);
    limit = 8'd1;
    cyc(1, 0, 0, 0);
    ticks(2);
    limit = 8'd2;
    cyc(0, 1, 0, 0);
    ticks(7);
    chk(1'b0, "R6");
    ticks(1);
    chk(1'b1, "R6");
  endtask

  task automatic t_start_ignored();
    cyc(0, 0, 0, 1);
    limit = 8'd1;
    cyc(1, 0, 0, 0);
    ticks(2);
    cyc(1, 0, 0, 0);
    ticks(2);
    chk(1'b1, "R9");
  endtask

  task automatic t_restart_priority();
    cyc(0, 0, 0, 1);
    limit = 8'd1;
    cyc(1, 0, 0, 0);
    ticks(2);
    cyc(0, 1, 1, 1);
    ticks(10);
    chk(1'b0, "R8");
    cyc(0, 0, 1, 1);
    chk(1'b0, "R8");
  endtask

  task automatic t_max();
    cyc(0, 0, 0, 1);
    limit = 8'd255;
    cyc(1, 0, 0, 0);
    ticks(1019);
    chk(1'b0, "R4");
    ticks(1);
    chk(1'b1, "R4");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dormant();
    t_basic();
    t_restart();
    t_zero();
    t_reload();
    t_newlimit();
    t_start_ignored();
    t_restart_priority();
    t_max();
    summary();
  end
endmodule